// File: doc/BRIEF.md
# HBM Pseudo-Channel Burst Dispatcher

This block takes memory transactions, each carrying a read/write direction, a byte offset into HBM, a chunk count and a requester tag. It cuts every transaction into burst-sized chunks. Each chunk goes to the pseudo-channel named by that chunk's own address bits, so a transaction's consecutive chunks walk across the channels and wrap around. There is no shared round-robin pointer.

Each pseudo-channel keeps a busy-until down-counter and remembers the direction it last served. A chunk waits until its channel is about to go idle. When the direction flips, the chunk also pays a turnaround penalty. A fixed overhead is charged once before a transaction's first chunk.

Up to a set number of transactions may be in flight. Each one holds a slot that tracks the latest finish among its chunks. The slot raises a response once every chunk has drained. Draining does not hold up dispatch: the next transaction can start issuing chunks while earlier chunks are still in service on other channels. Time is counted in clock cycles throughout.

Top module: `pc_burst_dispatch`

## Requirements
- R1: A chunk at byte offset A is served by channel (A >> log2(BURST_BYTES)) & (NUM_PCS-1). NUM_PCS and BURST_BYTES are powers of two. With the defaults (256-byte bursts, 8 channels) offset bits [10:8] pick the channel. Bits [7:0] and all bits above 10 have no effect on the choice.
- R2: The field `req_len` holds the chunk count minus one. Chunk i has offset base + i*BURST_BYTES, so the chunks rotate through the channels and wrap after NUM_PCS*BURST_BYTES bytes.
- R3: After a transaction is accepted, OVH_CYC cycles of overhead pass before its first chunk can be granted. For a single chunk on an idle channel with no turnaround, `rsp_valid` rises OVH_CYC+1+SVC_CYC cycles after the accepting clock edge.
- R4: A chunk is granted only once its channel has at most one busy cycle left. Two chunks on the same channel therefore start exactly SVC_CYC cycles apart when no turnaround applies.
- R5: A chunk whose direction differs from the channel's previous chunk occupies the channel for SVC_CYC+SW_CYC cycles. A channel that has not been used since reset pays no penalty.
- R6: A transaction's response is raised only after the latest finish among all of its chunks.
- R7: Chunks of different transactions on distinct channels overlap in service. A new transaction is accepted as soon as the previous one has issued its last chunk, without waiting for that chunk to drain.
- R8: At most MAX_OUT transactions are outstanding. While all slots are held, `req_ready` stays low.
- R9: `rsp_id` returns the `req_id` of the completed transaction. While `rsp_valid` is high and `rsp_ready` is low, both signals hold steady.
- R10: While reset is asserted and right after it is released, `req_ready` is high, `rsp_valid` is low, every busy counter is zero and every channel's last direction is "none".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transaction offered |
| req_ready | output | 1 | Transaction can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | ADDR_W | HBM byte offset of the first chunk |
| req_len | input | LEN_W | Number of chunks minus one |
| req_id | input | ID_W | Requester tag, returned on completion |
| rsp_valid | output | 1 | A transaction has fully drained |
| rsp_ready | input | 1 | Response taken this cycle |
| rsp_id | output | ID_W | Tag of the completed transaction |

## Verification
Any fault in the internal state shows up as a shift in response timing, because every response is timed to the exact cycle. A wrong channel index moves a chunk onto a channel that is busy, or onto one that is idle. A corrupted last-direction flag adds or drops the turnaround cycles. A slot whose finish counter is off by one answers one cycle early or late. All of these appear at `rsp_valid` within one service window of the faulty grant. Two further faults are caught in the same way. A dispatcher that waits for a drain, or that serializes distinct channels, delays the second response of a back-to-back pair by at least one full service time. A lost slot shows up as a missing response, or as a `req_ready` that is wrong while responses are held back.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  typedef enum logic [1:0] {
    DIR_NONE = 2'd0,
    DIR_RD   = 2'd1,
    DIR_WR   = 2'd2
  } pc_dir_e;
endpackage

// File: rtl/pcd_channel.sv
module pcd_channel
  import pcd_pkg::*;
#(
  parameter int SVC_CYC = 8,
  parameter int SW_CYC  = 3,
  parameter int CW      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          grant,
  input  logic          want_wr,
  output logic          free,
  output logic [CW-1:0] load_val
);
  pc_dir_e       dir_q, dir_d, want_dir;
  logic [CW-1:0] busy_q, busy_d;
  logic          turn;

  assign want_dir = want_wr ? DIR_WR : DIR_RD;
  assign turn     = (dir_q != DIR_NONE) && (dir_q != want_dir);
  assign load_val = turn ? CW'(SVC_CYC + SW_CYC) : CW'(SVC_CYC);
  assign free     = (busy_q <= CW'(1));

  always_comb begin
    busy_d = (busy_q != '0) ? busy_q - CW'(1) : '0;
    dir_d  = dir_q;
    if (grant) begin
      busy_d = load_val;
      dir_d  = want_dir;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
      dir_q  <= DIR_NONE;
    end else begin
      busy_q <= busy_d;
      dir_q  <= dir_d;
    end
  end

  // R4: the dispatcher grants only a channel in its last busy cycle or idle
  p_grant_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> busy_q <= CW'(1));
  // R5: first use after reset costs plain service time
  p_first_use_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && dir_q == DIR_NONE) |=> busy_q == CW'(SVC_CYC));
  // R5: a direction flip adds the turnaround
  p_turnaround_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && dir_q != DIR_NONE && dir_q != want_dir) |=> busy_q == CW'(SVC_CYC + SW_CYC));
endmodule

// File: rtl/pcd_dispatch.sv
module pcd_dispatch #(
  parameter int ADDR_W      = 37,
  parameter int LEN_W       = 4,
  parameter int NUM_PCS     = 8,
  parameter int BURST_BYTES = 256,
  parameter int OVH_CYC     = 2,
  parameter int SLW         = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               load_wr,
  input  logic [ADDR_W-1:0]  load_addr,
  input  logic [LEN_W-1:0]   load_len,
  input  logic [SLW-1:0]     load_slot,
  input  logic [NUM_PCS-1:0] pc_free,
  output logic               active,
  output logic [NUM_PCS-1:0] grant_vec,
  output logic               grant_wr,
  output logic [SLW-1:0]     grant_slot,
  output logic               grant_last
);
  localparam int SHIFT = $clog2(BURST_BYTES);
  localparam int PCW   = $clog2(NUM_PCS);
  localparam int OW    = $clog2(OVH_CYC + 2);

  logic              act_q, act_d, wr_q, wr_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  left_q, left_d;
  logic [SLW-1:0]    slot_q, slot_d;
  logic [OW-1:0]     ovh_q, ovh_d;
  logic [PCW-1:0]    pc;
  logic              fire;

  assign pc         = addr_q[SHIFT +: PCW];
  assign fire       = act_q && (ovh_q == '0) && pc_free[pc];
  assign grant_vec  = fire ? (NUM_PCS'(1) << pc) : '0;
  assign grant_wr   = wr_q;
  assign grant_slot = slot_q;
  assign grant_last = (left_q == '0);
  assign active     = act_q;

  always_comb begin
    act_d = act_q; wr_d = wr_q; addr_d = addr_q;
    left_d = left_q; slot_d = slot_q; ovh_d = ovh_q;
    if (load) begin
      act_d  = 1'b1;
      wr_d   = load_wr;
      addr_d = load_addr;
      left_d = load_len;
      slot_d = load_slot;
      ovh_d  = OW'(OVH_CYC);
    end else if (act_q && ovh_q != '0) begin
      ovh_d = ovh_q - OW'(1);
    end else if (fire) begin
      addr_d = addr_q + ADDR_W'(BURST_BYTES);
      left_d = left_q - LEN_W'(1);
      if (left_q == '0) act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0; wr_q <= 1'b0; addr_q <= '0;
      left_q <= '0; slot_q <= '0; ovh_q <= '0;
    end else begin
      act_q <= act_d; wr_q <= wr_d; addr_q <= addr_d;
      left_q <= left_d; slot_q <= slot_d; ovh_q <= ovh_d;
    end
  end

  // R7: a new transaction is loaded only once the previous one has issued all chunks
  p_load_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !act_q);
endmodule

// File: rtl/pcd_slot_table.sv
module pcd_slot_table #(
  parameter int SLOTS = 4,
  parameter int SLW   = 2,
  parameter int ID_W  = 4,
  parameter int CW    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc,
  input  logic [ID_W-1:0] alloc_id,
  output logic [SLW-1:0]  alloc_slot,
  output logic            has_free,
  input  logic            grant,
  input  logic [SLW-1:0]  grant_slot,
  input  logic            grant_last,
  input  logic [CW-1:0]   grant_load,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [ID_W-1:0] rsp_id
);
  logic [SLOTS-1:0] used_q, used_d, disp_q, disp_d, done;
  logic [ID_W-1:0]  id_q [SLOTS];
  logic [ID_W-1:0]  id_d [SLOTS];
  logic [CW-1:0]    fin_q [SLOTS];
  logic [CW-1:0]    fin_d [SLOTS];
  logic [SLW-1:0]   free_idx, done_idx, sel_q, rsp_sel;
  logic             any_done, hold_q, pop;

  for (genvar g = 0; g < SLOTS; g++) begin : g_done
    assign done[g] = used_q[g] && disp_q[g] && (fin_q[g] == '0);
  end

  always_comb begin
    free_idx = '0; has_free = 1'b0; done_idx = '0; any_done = 1'b0;
    for (int k = 0; k < SLOTS; k++) begin
      if (!used_q[k] && !has_free) begin free_idx = SLW'(k); has_free = 1'b1; end
      if (done[k] && !any_done) begin done_idx = SLW'(k); any_done = 1'b1; end
    end
  end

  assign rsp_sel    = hold_q ? sel_q : done_idx;
  assign rsp_valid  = hold_q || any_done;
  assign rsp_id     = id_q[rsp_sel];
  assign pop        = rsp_valid && rsp_ready;
  assign alloc_slot = free_idx;

  always_comb begin
    used_d = used_q; disp_d = disp_q;
    for (int k = 0; k < SLOTS; k++) begin
      id_d[k]  = id_q[k];
      fin_d[k] = (fin_q[k] != '0) ? fin_q[k] - CW'(1) : '0;
      if (grant && grant_slot == SLW'(k)) begin
        if (grant_load > fin_d[k]) fin_d[k] = grant_load;
        if (grant_last) disp_d[k] = 1'b1;
      end
      if (pop && rsp_sel == SLW'(k)) used_d[k] = 1'b0;
      if (alloc && free_idx == SLW'(k)) begin
        used_d[k] = 1'b1; disp_d[k] = 1'b0; id_d[k] = alloc_id; fin_d[k] = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= '0; disp_q <= '0; hold_q <= 1'b0; sel_q <= '0;
      for (int k = 0; k < SLOTS; k++) begin
        id_q[k] <= '0; fin_q[k] <= '0;
      end
    end else begin
      used_q <= used_d; disp_q <= disp_d;
      hold_q <= rsp_valid && !rsp_ready;
      sel_q  <= rsp_sel;
      for (int k = 0; k < SLOTS; k++) begin
        id_q[k] <= id_d[k]; fin_q[k] <= fin_d[k];
      end
    end
  end

  // R8: the front end allocates only while a slot is free
  p_alloc_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> !used_q[free_idx]);
  // R6: a response is shown only for a fully dispatched, drained slot
  p_rsp_drained_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (disp_q[rsp_sel] && fin_q[rsp_sel] == '0));
endmodule

// File: rtl/pc_burst_dispatch.sv
module pc_burst_dispatch #(
  parameter int ADDR_W      = 37,
  parameter int LEN_W       = 4,
  parameter int ID_W        = 4,
  parameter int NUM_PCS     = 8,
  parameter int BURST_BYTES = 256,
  parameter int MAX_OUT     = 4,
  parameter int SVC_CYC     = 8,
  parameter int SW_CYC      = 3,
  parameter int OVH_CYC     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_offset,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [ID_W-1:0]   req_id,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ID_W-1:0]   rsp_id
);
  localparam int CW  = $clog2(SVC_CYC + SW_CYC + 1);
  localparam int SLW = (MAX_OUT > 1) ? $clog2(MAX_OUT) : 1;

  logic               accept, dsp_act, has_free, g_wr, g_last, any_grant;
  logic [SLW-1:0]     alloc_slot, g_slot;
  logic [NUM_PCS-1:0] pc_free, grant_vec;
  logic [CW-1:0]      ch_load [NUM_PCS];
  logic [CW-1:0]      g_load;

  assign req_ready = !dsp_act && has_free;
  assign accept    = req_valid && req_ready;
  assign any_grant = |grant_vec;

  always_comb begin
    g_load = '0;
    for (int k = 0; k < NUM_PCS; k++)
      if (grant_vec[k]) g_load = ch_load[k];
  end

  pcd_dispatch #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .NUM_PCS(NUM_PCS),
    .BURST_BYTES(BURST_BYTES), .OVH_CYC(OVH_CYC), .SLW(SLW)
  ) u_dispatch (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_wr(req_write),
    .load_addr(req_offset), .load_len(req_len), .load_slot(alloc_slot),
    .pc_free(pc_free), .active(dsp_act), .grant_vec(grant_vec),
    .grant_wr(g_wr), .grant_slot(g_slot), .grant_last(g_last)
  );

  for (genvar g = 0; g < NUM_PCS; g++) begin : g_ch
    pcd_channel #(.SVC_CYC(SVC_CYC), .SW_CYC(SW_CYC), .CW(CW)) u_ch (
      .clk(clk), .rst_n(rst_n), .grant(grant_vec[g]), .want_wr(g_wr),
      .free(pc_free[g]), .load_val(ch_load[g])
    );
  end

  pcd_slot_table #(.SLOTS(MAX_OUT), .SLW(SLW), .ID_W(ID_W), .CW(CW)) u_slots (
    .clk(clk), .rst_n(rst_n), .alloc(accept), .alloc_id(req_id),
    .alloc_slot(alloc_slot), .has_free(has_free), .grant(any_grant),
    .grant_slot(g_slot), .grant_last(g_last), .grant_load(g_load),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_id(rsp_id)
  );

  // R9: a stalled response keeps its valid and tag
  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_id)));
endmodule

// File: tb/test_pc_burst_dispatch.sv
module test_pc_burst_dispatch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [36:0] req_offset = '0;
  logic [3:0]  req_len = '0, req_id = '0;
  logic        req_ready, rsp_valid;
  logic [3:0]  rsp_id;

  int cyc = 0, checks = 0, errors = 0;
  int acc_time [16];
  int rsp_time [16];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pc_burst_dispatch i_pc_burst_dispatch (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_offset(req_offset), .req_len(req_len),
    .req_id(req_id), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_id(rsp_id)
  );

  always @(negedge clk)
    if (rst_n && rsp_valid && rsp_ready) rsp_time[rsp_id] = cyc;

  task automatic check(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_valid = 1'b0; rsp_ready = 1'b1;
    for (int k = 0; k < 16; k++) begin acc_time[k] = -1; rsp_time[k] = -1; end
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send(input int id, input bit wr, input logic [36:0] off, input int len);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_offset = off;
    req_len = 4'(len); req_id = 4'(id);
    while (!req_ready) @(negedge clk);
    acc_time[id] = cyc + 1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_rsp(input int id, input string req);
    int n = 0;
    while (rsp_time[id] < 0 && n < 200) begin @(negedge clk); n++; end
    if (rsp_time[id] < 0) check(0, 1, {req, " response missing"});
  endtask

  task automatic latency(input int id, input int exp, input string req);
    wait_rsp(id, req);
    check(rsp_time[id] - acc_time[id], exp, req);
  endtask

  task automatic t_reset();
    do_reset();
    check(int'(req_ready), 1, "R10 req_ready after reset");
    check(int'(rsp_valid), 0, "R10 rsp_valid after reset");
  endtask

  task automatic t_single();
    do_reset();
    send(1, 1'b1, 37'h300, 0);
    latency(1, 11, "R3 single chunk overhead+service");
    send(2, 1'b0, 37'h10_0000_0300, 0);
    latency(2, 14, "R5 turnaround with R1 upper bits ignored");
    send(3, 1'b0, 37'h500, 0);
    latency(3, 11, "R5 unused channel no penalty");
    send(4, 1'b0, 37'h3A5, 0);
    latency(4, 11, "R1 low bits ignored same-dir pc3");
  endtask

  task automatic t_stripe();
    do_reset();
    send(1, 1'b1, 37'h500, 3);
    latency(1, 14, "R2 four chunks wrap pc5..pc0");
    send(2, 1'b1, 37'h000, 8);
    latency(2, 19, "R2 R4 nine chunks reuse pc0");
  endtask

  task automatic t_parallel();
    do_reset();
    send(1, 1'b1, 37'h000, 0);
    send(2, 1'b1, 37'h100, 0);
    latency(1, 11, "R7 first of pair");
    latency(2, 11, "R7 second accepted before first drained");
    check(rsp_time[2] - acc_time[1], 15, "R7 distinct channels overlap");
    do_reset();
    send(1, 1'b1, 37'h000, 0);
    send(2, 1'b1, 37'h800, 0);
    latency(1, 11, "R4 first on pc0");
    latency(2, 15, "R4 same channel serializes");
    check(rsp_time[2] - rsp_time[1], 8, "R4 R6 back to back spacing");
  endtask

  task automatic t_backpressure();
    do_reset();
    rsp_ready = 1'b0;
    for (int k = 1; k <= 4; k++) send(k, 1'b1, 37'(k * 256), 0);
    repeat (30) @(negedge clk);
    check(int'(req_ready), 0, "R8 full table blocks requests");
    check(int'(rsp_valid), 1, "R9 response pending");
    check(int'(rsp_id), 1, "R9 held tag");
    repeat (5) @(negedge clk);
    check(int'(rsp_id), 1, "R9 tag stable under stall");
    rsp_ready = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      wait_rsp(k, "R9 drain");
      check(int'(rsp_time[k] >= 0), 1, "R9 R6 every tag returned");
    end
    @(negedge clk);
    check(int'(req_ready), 1, "R8 slots released");
  endtask

  bit finished = 0;
  initial begin
    t_reset();
    t_single();
    t_stripe();
    t_parallel();
    t_backpressure();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected 0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule